// File: doc/BRIEF.md
# Processor Reset and Strap Sequencer

This block produces the active-low reset for a host processor from the platform reset of the board. It also drives a configuration strap on the processor's bus-request pin while that reset is active. The platform reset is brought into the bus clock domain through a two-flop synchroniser. Assertion of the platform reset takes effect at once. Its release is followed by a long, parameterised stretch of bus clocks before the processor reset lets go.

The strap starts driven at its configured level. It stays driven through the whole stretch, which gives the processor at least four clocks of setup before the release edge. It is still driven for a fixed hold window after that edge, and only then is the driver turned off. When the driver turns off, a sticky flag tells the ordinary bus-request logic that it may take over the pin. If the platform reset returns at any point, every output goes back to its reset value and the whole sequence starts again from the beginning.

Top module: `cpurst_seq`

## Requirements
- R1: `cpuRstN` is 0 whenever `platRstN` is 0. This takes effect without waiting for a clock edge.
- R2: Count the rising clock edges with `platRstN` held at 1, starting at 1 for the first edge after it rises. `cpuRstN` becomes 1 right after edge number 2 + `STRETCH_CLKS`. It is 0 before that edge.
- R3: While `cpuRstN` is 0, `strapOe` is 1 and `strapVal` equals `STRAP_LEVEL` (default 0, a low drive).
- R4: `strapOe` has been 1 for at least 4 clock cycles before `cpuRstN` rises. `STRETCH_CLKS` below 4 is rejected at elaboration.
- R5: After `cpuRstN` rises, `strapOe` stays 1 for exactly `HOLD_CLKS` more rising edges and then goes to 0. `HOLD_CLKS` outside 2..20 is rejected at elaboration. The default is 4.
- R6: `pinFree` is 0 while the strap is driven. It becomes 1 on the same edge that `strapOe` goes to 0, and stays 1 until `platRstN` is asserted again.
- R7: Asserting `platRstN` during the stretch, during the hold window or after completion returns all outputs to their reset values at once. A later release replays the full sequence from R2 onward. A release shorter than the sequence leaves `cpuRstN` at 0 throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| platRstN | input | 1 | Platform reset, active low |
| cpuRstN | output | 1 | Processor reset, active low |
| strapVal | output | 1 | Level placed on the strap pin while it is driven |
| strapOe | output | 1 | Strap driver enable; 0 means the pin floats |
| pinFree | output | 1 | Pin handed over to normal bus-request use |

## Verification
Three instances with different stretch and hold lengths, including the minimum hold of 2 and the maximum of 20, are checked against a model that counts edges since release. A counter that is off by one, or a synchroniser with a missing stage, would move the release edge, and this shows up as a mismatch in the exact cycle of `cpuRstN` or `strapOe`. The bench reasserts the platform reset during the stretch, during the hold window and after completion. A design that failed to restart fully would leave the strap floating or `pinFree` stuck high on the second run. A one-cycle release pulse catches a design that lets the processor out of reset on a short glitch.

// File: rtl/cpurst_pkg.sv
package cpurst_pkg;

  typedef enum logic [1:0] {
    PH_STRETCH = 2'd0,
    PH_HOLD    = 2'd1,
    PH_DONE    = 2'd2
  } seqPhase_t;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic relCpu;
    logic relStrap;
  } seqStrobe_t;

endpackage

// File: rtl/cpurst_dp.sv
module cpurst_dp
  import cpurst_pkg::*;
#(
  parameter int unsigned STRETCH_CLKS = 100000,
  parameter int unsigned HOLD_CLKS    = 4,
  parameter bit          STRAP_LEVEL  = 1'b0,
  parameter int unsigned CNT_W        = 17
) (
  input  logic       clk,
  input  logic       platRstN,
  input  seqStrobe_t strobe,
  output logic       rstLive,
  output logic       stretchDone,
  output logic       holdDone,
  output logic       cpuRstN,
  output logic       strapVal,
  output logic       strapOe,
  output logic       pinFree
);

  localparam logic [CNT_W-1:0] STRETCH_LAST = CNT_W'(STRETCH_CLKS - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST    = CNT_W'(HOLD_CLKS - 1);

  logic syncA, syncB;
  logic [CNT_W-1:0] cnt;

  // two-flop synchroniser: asserts at once, releases on the clock
  always_ff @(posedge clk or negedge platRstN) begin
    if (!platRstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
    end else begin
      syncA <= 1'b1;
      syncB <= syncA;
    end
  end

  assign rstLive = syncB;

  always_ff @(posedge clk or negedge platRstN) begin
    if (!platRstN) begin
      cnt <= '0;
    end else if (strobe.cntClr) begin
      cnt <= '0;
    end else if (strobe.cntInc) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign stretchDone = (cnt == STRETCH_LAST);
  assign holdDone    = (cnt == HOLD_LAST);

  always_ff @(posedge clk or negedge platRstN) begin
    if (!platRstN) begin
      cpuRstN <= 1'b0;
      strapOe <= 1'b1;
      pinFree <= 1'b0;
    end else begin
      if (strobe.relCpu) begin
        cpuRstN <= 1'b1;
      end
      if (strobe.relStrap) begin
        strapOe <= 1'b0;
        pinFree <= 1'b1;
      end
    end
  end

  assign strapVal = STRAP_LEVEL;

  AST_RST_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (!platRstN)
    !rstLive |-> !cpuRstN) else $error("processor reset left before sync release"); // R1

  AST_STRAP_COVERS_RST: assert property (@(posedge clk) disable iff (!platRstN)
    !cpuRstN |-> strapOe) else $error("strap floated during reset"); // R3

  AST_STRAP_SETUP: assert property (@(posedge clk) disable iff (!platRstN)
    $rose(cpuRstN) |-> ($past(strapOe, 1) && $past(strapOe, 4))) else $error("strap setup short"); // R4

  AST_STRAP_HOLD_MIN: assert property (@(posedge clk) disable iff (!platRstN)
    $fell(strapOe) |-> (cpuRstN && $past(cpuRstN, 2))) else $error("strap hold short"); // R5

  AST_PIN_FREE_STICKY: assert property (@(posedge clk) disable iff (!platRstN)
    pinFree |=> pinFree) else $error("pin handover dropped"); // R6

endmodule

// File: rtl/cpurst_ctl.sv
module cpurst_ctl
  import cpurst_pkg::*;
(
  input  logic       clk,
  input  logic       platRstN,
  input  logic       rstLive,
  input  logic       stretchDone,
  input  logic       holdDone,
  output seqStrobe_t strobe
);

  seqPhase_t phase, phaseNxt;

  always_ff @(posedge clk or negedge platRstN) begin
    if (!platRstN) begin
      phase <= PH_STRETCH;
    end else begin
      phase <= phaseNxt;
    end
  end

  always_comb begin
    phaseNxt = phase;
    strobe   = '0;
    unique case (phase)
      PH_STRETCH: begin
        if (rstLive) begin
          if (stretchDone) begin
            strobe.relCpu = 1'b1;
            strobe.cntClr = 1'b1;
            phaseNxt      = PH_HOLD;
          end else begin
            strobe.cntInc = 1'b1;
          end
        end
      end
      PH_HOLD: begin
        if (holdDone) begin
          strobe.relStrap = 1'b1;
          strobe.cntClr   = 1'b1;
          phaseNxt        = PH_DONE;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      PH_DONE: begin
        phaseNxt = PH_DONE;
      end
      default: begin
        phaseNxt = PH_STRETCH;
      end
    endcase
  end

  AST_DONE_IS_FINAL: assert property (@(posedge clk) disable iff (!platRstN)
    (phase == PH_DONE) |=> (phase == PH_DONE)) else $error("sequence left done phase"); // R7

  AST_NO_RELEASE_UNSYNCED: assert property (@(posedge clk) disable iff (!platRstN)
    !rstLive |-> (strobe == '0)) else $error("sequencer moved before sync"); // R2

endmodule

// File: rtl/cpurst_seq.sv
module cpurst_seq
  import cpurst_pkg::*;
#(
  parameter int unsigned STRETCH_CLKS = 100000,
  parameter int unsigned HOLD_CLKS    = 4,
  parameter bit          STRAP_LEVEL  = 1'b0
) (
  input  logic clk,
  input  logic platRstN,
  output logic cpuRstN,
  output logic strapVal,
  output logic strapOe,
  output logic pinFree
);

  localparam int unsigned MIN_SETUP = 4;
  localparam int unsigned CNT_MAX   = (STRETCH_CLKS > HOLD_CLKS) ? STRETCH_CLKS : HOLD_CLKS;
  localparam int unsigned CNT_W     = $clog2(CNT_MAX + 1);

  generate
    if (HOLD_CLKS < 2 || HOLD_CLKS > 20) begin : gBadHold
      $error("HOLD_CLKS must lie within 2..20");
    end
    if (STRETCH_CLKS < MIN_SETUP) begin : gBadStretch
      $error("STRETCH_CLKS must be at least 4");
    end
  endgenerate

  seqStrobe_t strobe;
  logic rstLive, stretchDone, holdDone;

  cpurst_ctl u_ctl (
    .clk        (clk),
    .platRstN   (platRstN),
    .rstLive    (rstLive),
    .stretchDone(stretchDone),
    .holdDone   (holdDone),
    .strobe     (strobe)
  );

  cpurst_dp #(
    .STRETCH_CLKS(STRETCH_CLKS),
    .HOLD_CLKS   (HOLD_CLKS),
    .STRAP_LEVEL (STRAP_LEVEL),
    .CNT_W       (CNT_W)
  ) u_dp (
    .clk        (clk),
    .platRstN   (platRstN),
    .strobe     (strobe),
    .rstLive    (rstLive),
    .stretchDone(stretchDone),
    .holdDone   (holdDone),
    .cpuRstN    (cpuRstN),
    .strapVal   (strapVal),
    .strapOe    (strapOe),
    .pinFree    (pinFree)
  );

endmodule

// File: tb/cpurst_seq_bench.sv
module cpurst_seq_bench;

  localparam int S0 = 12, H0 = 4;
  localparam int S1 = 4,  H1 = 20;
  localparam int S2 = 6,  H2 = 2;

  logic clk = 1'b0;
  logic platRstN = 1'b0;
  logic running = 1'b0;
  int   checks = 0;
  int   errors = 0;
  int   edgesUp = 0;
  int   oeRun [3];
  logic prevCpu [3];

  logic cpu [3], sval [3], soe [3], pfree [3];

  always #10 clk = ~clk;

  cpurst_seq #(.STRETCH_CLKS(S0), .HOLD_CLKS(H0)) u_cpurst_seq (
    .clk(clk), .platRstN(platRstN), .cpuRstN(cpu[0]), .strapVal(sval[0]),
    .strapOe(soe[0]), .pinFree(pfree[0]));
  cpurst_seq #(.STRETCH_CLKS(S1), .HOLD_CLKS(H1)) u_long (
    .clk(clk), .platRstN(platRstN), .cpuRstN(cpu[1]), .strapVal(sval[1]),
    .strapOe(soe[1]), .pinFree(pfree[1]));
  cpurst_seq #(.STRETCH_CLKS(S2), .HOLD_CLKS(H2)) u_short (
    .clk(clk), .platRstN(platRstN), .cpuRstN(cpu[2]), .strapVal(sval[2]),
    .strapOe(soe[2]), .pinFree(pfree[2]));

  function automatic int stretchOf(int i);
    return (i == 0) ? S0 : (i == 1) ? S1 : S2;
  endfunction
  function automatic int holdOf(int i);
    return (i == 0) ? H0 : (i == 1) ? H1 : H2;
  endfunction

  task automatic check(string tag, int inst, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s inst%0d edges=%0d actual=%b expected=%b", tag, inst, edgesUp, act, exp);
    end
  endtask

  // behavioural model: edges seen with platform reset released
  always @(posedge clk) begin
    if (!platRstN) edgesUp <= 0;
    else           edgesUp <= edgesUp + 1;
  end

  always @(negedge clk) begin
    if (running) begin
      for (int i = 0; i < 3; i++) begin
        logic expCpu, expOe;
        expCpu = platRstN && (edgesUp >= 2 + stretchOf(i));
        expOe  = !(platRstN && (edgesUp >= 2 + stretchOf(i) + holdOf(i)));
        check(platRstN ? "R2" : "R1", i, cpu[i], expCpu);
        check(expCpu ? "R5" : "R3", i, soe[i], expOe);
        check("R3", i, sval[i], 1'b0);
        check("R6", i, pfree[i], !expOe);
        if (cpu[i] && !prevCpu[i]) check("R4", i, (oeRun[i] >= 4), 1'b1);
        oeRun[i]   = soe[i] ? oeRun[i] + 1 : 0;
        prevCpu[i] = cpu[i];
      end
    end
  end

  task automatic waitCycles(int n);
    for (int c = 0; c < n; c++) @(negedge clk);
    #5;
  endtask

  task automatic assertNow();
    platRstN = 1'b0;
    #1;
    for (int i = 0; i < 3; i++) begin
      check("R7", i, cpu[i], 1'b0);
      check("R7", i, soe[i], 1'b1);
      check("R7", i, pfree[i], 1'b0);
    end
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin
      oeRun[i] = 0;
      prevCpu[i] = 1'b0;
    end
    running = 1'b1;
    waitCycles(4);
    platRstN = 1'b1;                 // first full sequence
    waitCycles(40);
    assertNow();                     // R7 after completion
    waitCycles(3);
    platRstN = 1'b1;
    waitCycles(9);
    assertNow();                     // R7 during stretch of inst0, hold of others
    waitCycles(2);
    platRstN = 1'b1;
    waitCycles(16);
    assertNow();                     // R7 inside hold of inst0, long hold of inst1
    waitCycles(2);
    platRstN = 1'b1;                 // one-cycle glitch release
    waitCycles(1);
    platRstN = 1'b0;
    waitCycles(5);
    platRstN = 1'b1;                 // final full replay
    waitCycles(40);
    running = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule